// File: doc/BRIEF.md
# Cross-Side Flag and Interrupt Request Signalling

This block carries lightweight signalling between two processors, called side A and side B, that share a mailbox. Each side owns a small flag field. A value written there is copied to the other side after a fixed transfer delay. While a copy is in flight, the writing side sees a busy indication, and further flag writes from that side are refused.

Each side can also raise four general-purpose interrupt requests and one non-maskable request toward its peer. A request bit set by one side appears on the peer as a pending interrupt line. It stays set until the peer acknowledges it. The requester cannot clear it, and writing it again has no effect while it is pending. The block is symmetric, and the two directions work independently of each other.

Top module: `xcore_signal`

## Requirements
- R1: After reset, both sides show a flag value of 0, a busy indication of 0, a peer flag view of 0, and no request or pending bits set. A reset asserted in mid-run returns the block to this state.
- R2: A flag write on a side whose busy indication is low takes effect at the next clock edge. After that edge the side's own flag output holds the written value and its busy indication is 1. This holds even when the written value equals the old one.
- R3: After an accepted flag write, the busy indication stays high for exactly two cycles. The peer's view of the flags takes the new value at the same edge at which busy falls, and not before.
- R4: A flag write presented while the side's busy indication is high is ignored. The side's own flag value does not change, and the transfer in progress completes on its original schedule.
- R5: On a request write, every general-purpose request bit (bit i of the request input, i = 0 to 3) presented as 1 becomes set in the requester's control bits at the next edge. The same bit i appears on the peer's pending output.
- R6: On a request write, a 0 in any request bit leaves that bit unchanged. Writing 1 to a bit that is already pending leaves it pending.
- R7: A pending request bit clears at the next edge only when the peer presents an acknowledge strobe with 1 in the matching bit. If the same bit is both acknowledged and re-requested in one cycle while it is pending, it clears. An acknowledge of a bit that is not pending does not block a request of that bit in the same cycle. Acknowledge data with the strobe low has no effect.
- R8: The non-maskable request has its own request, acknowledge and pending bits. It follows the same set and clear rules as the general-purpose requests, and it is independent of them.
- R9: Flag transfer and requests from side B to side A behave in the same way as from A to B, with the roles of the sides swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rstN | input | 1 | Active-low synchronous reset |
| aFlagWe | input | 1 | Side A flag write strobe |
| aFlagIn | input | 3 | Side A flag write data |
| aReqWe | input | 1 | Side A request write strobe |
| aGpReqIn | input | 4 | Side A general-purpose request write data (1 = raise) |
| aNmiReqIn | input | 1 | Side A non-maskable request write data (1 = raise) |
| aAckWe | input | 1 | Side A acknowledge strobe |
| aGpAckIn | input | 4 | Side A acknowledge of B's general-purpose requests (1 = accept) |
| aNmiAckIn | input | 1 | Side A acknowledge of B's non-maskable request |
| aFlagOwn | output | 3 | Side A's own flag value |
| aFlagBusy | output | 1 | Side A flag transfer in progress |
| aPeerFlags | output | 3 | Flag value published by side B |
| aGpReq | output | 4 | Side A general-purpose requests still pending at B |
| aNmiReq | output | 1 | Side A non-maskable request still pending at B |
| aGpPend | output | 4 | General-purpose interrupt lines from B, pending at A |
| aNmiPend | output | 1 | Non-maskable interrupt line from B, pending at A |
| bFlagWe | input | 1 | Side B flag write strobe |
| bFlagIn | input | 3 | Side B flag write data |
| bReqWe | input | 1 | Side B request write strobe |
| bGpReqIn | input | 4 | Side B general-purpose request write data |
| bNmiReqIn | input | 1 | Side B non-maskable request write data |
| bAckWe | input | 1 | Side B acknowledge strobe |
| bGpAckIn | input | 4 | Side B acknowledge of A's general-purpose requests |
| bNmiAckIn | input | 1 | Side B acknowledge of A's non-maskable request |
| bFlagOwn | output | 3 | Side B's own flag value |
| bFlagBusy | output | 1 | Side B flag transfer in progress |
| bPeerFlags | output | 3 | Flag value published by side A |
| bGpReq | output | 4 | Side B general-purpose requests still pending at A |
| bNmiReq | output | 1 | Side B non-maskable request still pending at A |
| bGpPend | output | 4 | General-purpose interrupt lines from A, pending at B |
| bNmiPend | output | 1 | Non-maskable interrupt line from A, pending at B |

## Verification
The assertions watch the A-to-B direction on every cycle. They check that an accepted flag write raises busy, that busy lasts exactly two cycles, and that the own flag value cannot move while busy is high. They also check that the peer view changes only at the edge where busy falls, that a written request bit is set afterwards, and that no request bit drops without a matching acknowledge. Some properties cover combinations of events rather than single cycles, and only the bench scenarios can show them: the exact values that reach the peer, an acknowledge colliding with a re-request, an acknowledge of an idle bit, the B-to-A direction, and a reset asserted in mid-run.

// File: rtl/xsig_pkg.sv
package xsig_pkg;
  // Widths of the signalling fields.
  localparam int unsigned FLAG_W = 3;
  localparam int unsigned GP_N   = 4;
  // General-purpose requests occupy bits GP_N-1:0; the non-maskable request sits at bit GP_N.
  localparam int unsigned REQ_W  = GP_N + 1;

  // Strobes from control to datapath for one side.
  typedef struct packed {
    logic             flagLoad;     // capture new own flag value
    logic             flagPublish;  // copy own flag value to the peer view
    logic [REQ_W-1:0] reqSet;       // request bits asked to be raised
    logic [REQ_W-1:0] reqClr;       // request bits acknowledged by the peer
  } strb_t;
endpackage

// File: rtl/xsig_ctrl.sv
module xsig_ctrl
  import xsig_pkg::*;
#(
  parameter int unsigned XFER_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flagWe,
  input  logic             reqWe,
  input  logic [REQ_W-1:0] reqIn,
  input  logic             peerAckWe,
  input  logic [REQ_W-1:0] peerAckIn,
  output strb_t            strb,
  output logic             busy
);
  localparam int unsigned CNT_W = $clog2(XFER_CYC + 1);

  logic [CNT_W-1:0] xferCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferCnt <= '0;
    end else if (strb.flagLoad) begin
      xferCnt <= CNT_W'(XFER_CYC);
    end else if (xferCnt != '0) begin
      xferCnt <= xferCnt - CNT_W'(1);
    end
  end

  always_comb begin
    busy             = (xferCnt != '0);
    strb.flagLoad    = flagWe && !busy;
    strb.flagPublish = (xferCnt == CNT_W'(1));
    strb.reqSet      = reqWe ? reqIn : '0;
    strb.reqClr      = peerAckWe ? peerAckIn : '0;
  end
endmodule

// File: rtl/xsig_dp.sv
module xsig_dp
  import xsig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [FLAG_W-1:0] flagIn,
  output logic [FLAG_W-1:0] flagOwn,
  output logic [FLAG_W-1:0] flagPub,
  output logic [REQ_W-1:0]  reqQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagOwn <= '0;
      flagPub <= '0;
      reqQ    <= '0;
    end else begin
      if (strb.flagLoad)    flagOwn <= flagIn;
      if (strb.flagPublish) flagPub <= flagOwn;
      // An acknowledge wins over a repeated trigger of a pending bit;
      // a trigger of an idle bit always lands.
      reqQ <= (reqQ & ~strb.reqClr) | (strb.reqSet & ~reqQ);
    end
  end
endmodule

// File: rtl/xcore_signal.sv
module xcore_signal
  import xsig_pkg::*;
#(
  parameter int unsigned XFER_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aFlagWe,
  input  logic [FLAG_W-1:0] aFlagIn,
  input  logic              aReqWe,
  input  logic [GP_N-1:0]   aGpReqIn,
  input  logic              aNmiReqIn,
  input  logic              aAckWe,
  input  logic [GP_N-1:0]   aGpAckIn,
  input  logic              aNmiAckIn,
  output logic [FLAG_W-1:0] aFlagOwn,
  output logic              aFlagBusy,
  output logic [FLAG_W-1:0] aPeerFlags,
  output logic [GP_N-1:0]   aGpReq,
  output logic              aNmiReq,
  output logic [GP_N-1:0]   aGpPend,
  output logic              aNmiPend,
  input  logic              bFlagWe,
  input  logic [FLAG_W-1:0] bFlagIn,
  input  logic              bReqWe,
  input  logic [GP_N-1:0]   bGpReqIn,
  input  logic              bNmiReqIn,
  input  logic              bAckWe,
  input  logic [GP_N-1:0]   bGpAckIn,
  input  logic              bNmiAckIn,
  output logic [FLAG_W-1:0] bFlagOwn,
  output logic              bFlagBusy,
  output logic [FLAG_W-1:0] bPeerFlags,
  output logic [GP_N-1:0]   bGpReq,
  output logic              bNmiReq,
  output logic [GP_N-1:0]   bGpPend,
  output logic              bNmiPend
);
  localparam int unsigned SIDES = 2;

  logic              flagWe  [SIDES];
  logic [FLAG_W-1:0] flagIn  [SIDES];
  logic              reqWe   [SIDES];
  logic [REQ_W-1:0]  reqIn   [SIDES];
  logic              ackWe   [SIDES];
  logic [REQ_W-1:0]  ackIn   [SIDES];
  logic [FLAG_W-1:0] flagOwn [SIDES];
  logic [FLAG_W-1:0] flagPub [SIDES];
  logic              busy    [SIDES];
  logic [REQ_W-1:0]  reqQ    [SIDES];
  strb_t             strb    [SIDES];

  assign flagWe[0] = aFlagWe;
  assign flagIn[0] = aFlagIn;
  assign reqWe[0]  = aReqWe;
  assign reqIn[0]  = {aNmiReqIn, aGpReqIn};
  assign ackWe[0]  = aAckWe;
  assign ackIn[0]  = {aNmiAckIn, aGpAckIn};
  assign flagWe[1] = bFlagWe;
  assign flagIn[1] = bFlagIn;
  assign reqWe[1]  = bReqWe;
  assign reqIn[1]  = {bNmiReqIn, bGpReqIn};
  assign ackWe[1]  = bAckWe;
  assign ackIn[1]  = {bNmiAckIn, bGpAckIn};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int unsigned PEER = SIDES - 1 - s;

    xsig_ctrl #(.XFER_CYC(XFER_CYC)) u_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .flagWe    (flagWe[s]),
      .reqWe     (reqWe[s]),
      .reqIn     (reqIn[s]),
      .peerAckWe (ackWe[PEER]),
      .peerAckIn (ackIn[PEER]),
      .strb      (strb[s]),
      .busy      (busy[s])
    );

    xsig_dp u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb[s]),
      .flagIn  (flagIn[s]),
      .flagOwn (flagOwn[s]),
      .flagPub (flagPub[s]),
      .reqQ    (reqQ[s])
    );
  end

  assign aFlagOwn   = flagOwn[0];
  assign aFlagBusy  = busy[0];
  assign aPeerFlags = flagPub[1];
  assign aGpReq     = reqQ[0][GP_N-1:0];
  assign aNmiReq    = reqQ[0][GP_N];
  assign aGpPend    = reqQ[1][GP_N-1:0];
  assign aNmiPend   = reqQ[1][GP_N];
  assign bFlagOwn   = flagOwn[1];
  assign bFlagBusy  = busy[1];
  assign bPeerFlags = flagPub[0];
  assign bGpReq     = reqQ[1][GP_N-1:0];
  assign bNmiReq    = reqQ[1][GP_N];
  assign bGpPend    = reqQ[0][GP_N-1:0];
  assign bNmiPend   = reqQ[0][GP_N];
endmodule

// File: rtl/xsig_chk.sv
module xsig_chk
  import xsig_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              aFlagWe,
  input logic              aFlagBusy,
  input logic [FLAG_W-1:0] aFlagOwn,
  input logic [FLAG_W-1:0] bPeerFlags,
  input logic              aReqWe,
  input logic [GP_N-1:0]   aGpReqIn,
  input logic              aNmiReqIn,
  input logic [GP_N-1:0]   aGpReq,
  input logic              aNmiReq,
  input logic              bAckWe,
  input logic [GP_N-1:0]   bGpAckIn,
  input logic              bNmiAckIn
);
  logic [REQ_W-1:0] aReqAll;
  logic [REQ_W-1:0] aReqWrite;
  logic [REQ_W-1:0] bAckMask;

  assign aReqAll   = {aNmiReq, aGpReq};
  assign aReqWrite = {aNmiReqIn, aGpReqIn};
  assign bAckMask  = bAckWe ? {bNmiAckIn, bGpAckIn} : '0;

  // R2: an accepted flag write raises busy
  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    (aFlagWe && !aFlagBusy) |=> aFlagBusy);

  // R3: busy lasts two cycles (default transfer length)
  a_r3_busy_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    (aFlagBusy && $past(aFlagBusy)) |=> !aFlagBusy);

  // R3: the peer view moves only at the edge that ends the transfer
  a_r3_peer_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bPeerFlags) |-> $fell(aFlagBusy));

  // R4: own flags are frozen while a transfer is in flight
  a_r4_flag_frozen: assert property (@(posedge clk) disable iff (!rstN)
    aFlagBusy |=> $stable(aFlagOwn));

  // R5, R8: written request bits are set afterwards when no acknowledge collides
  a_r5_set_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (aReqWe && !bAckWe) |=> ((aReqAll & $past(aReqWrite)) == $past(aReqWrite)));

  // R7: a request bit drops only with a matching acknowledge
  a_r7_clear_only_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    ((~aReqAll) & $past(aReqAll) & ~$past(bAckMask)) == '0);
endmodule

bind xcore_signal xsig_chk u_chk (.*);

// File: tb/test_xcore_signal.sv
`timescale 1ns/100ps
module test_xcore_signal;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic       aFlagWe = 0, aReqWe = 0, aNmiReqIn = 0, aAckWe = 0, aNmiAckIn = 0;
  logic [2:0] aFlagIn = 0;
  logic [3:0] aGpReqIn = 0, aGpAckIn = 0;
  logic       bFlagWe = 0, bReqWe = 0, bNmiReqIn = 0, bAckWe = 0, bNmiAckIn = 0;
  logic [2:0] bFlagIn = 0;
  logic [3:0] bGpReqIn = 0, bGpAckIn = 0;
  logic [2:0] aFlagOwn, aPeerFlags, bFlagOwn, bPeerFlags;
  logic       aFlagBusy, aNmiReq, aNmiPend, bFlagBusy, bNmiReq, bNmiPend;
  logic [3:0] aGpReq, aGpPend, bGpReq, bGpPend;

  xcore_signal i_xcore_signal (.*);

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idleInputs();
    aFlagWe = 0; aReqWe = 0; aAckWe = 0; aGpReqIn = 0; aNmiReqIn = 0; aGpAckIn = 0; aNmiAckIn = 0;
    bFlagWe = 0; bReqWe = 0; bAckWe = 0; bGpReqIn = 0; bNmiReqIn = 0; bGpAckIn = 0; bNmiAckIn = 0;
  endtask

  task automatic chkIdle(input string req);
    chk(req, "aFlagOwn", 8'(aFlagOwn), 8'd0);
    chk(req, "aFlagBusy", 8'(aFlagBusy), 8'd0);
    chk(req, "aPeerFlags", 8'(aPeerFlags), 8'd0);
    chk(req, "aReq", 8'({aNmiReq, aGpReq}), 8'd0);
    chk(req, "aPend", 8'({aNmiPend, aGpPend}), 8'd0);
    chk(req, "bFlagOwn", 8'(bFlagOwn), 8'd0);
    chk(req, "bFlagBusy", 8'(bFlagBusy), 8'd0);
    chk(req, "bPeerFlags", 8'(bPeerFlags), 8'd0);
    chk(req, "bReq", 8'({bNmiReq, bGpReq}), 8'd0);
    chk(req, "bPend", 8'({bNmiPend, bGpPend}), 8'd0);
  endtask

  // One cycle of A-to-B stimulus and the state expected after the edge.
  // Request fields are {non-maskable, gp[3:0]}.
  typedef struct packed {
    logic [3:0] rid;
    logic       fWe;
    logic [2:0] fIn;
    logic       rWe;
    logic [4:0] rIn;
    logic       kWe;
    logic [4:0] kIn;
    logic [2:0] eOwn;
    logic       eBusy;
    logic [2:0] ePeer;
    logic [4:0] eReq;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{4'd2, 1'b1, 3'd5, 1'b0, 5'h00, 1'b0, 5'h00, 3'd5, 1'b1, 3'd0, 5'h00}, // R2 accept flag 5
    '{4'd4, 1'b1, 3'd3, 1'b0, 5'h00, 1'b0, 5'h00, 3'd5, 1'b1, 3'd0, 5'h00}, // R4 write while busy
    '{4'd3, 1'b0, 3'd0, 1'b0, 5'h00, 1'b0, 5'h00, 3'd5, 1'b0, 3'd5, 5'h00}, // R3 peer sees 5
    '{4'd2, 1'b1, 3'd3, 1'b0, 5'h00, 1'b0, 5'h00, 3'd3, 1'b1, 3'd5, 5'h00}, // R2 accept flag 3
    '{4'd5, 1'b0, 3'd0, 1'b1, 5'h05, 1'b0, 5'h00, 3'd3, 1'b1, 3'd5, 5'h05}, // R5 raise gp0, gp2
    '{4'd5, 1'b0, 3'd0, 1'b1, 5'h02, 1'b0, 5'h00, 3'd3, 1'b0, 3'd3, 5'h07}, // R5 raise gp1
    '{4'd6, 1'b0, 3'd0, 1'b1, 5'h00, 1'b0, 5'h00, 3'd3, 1'b0, 3'd3, 5'h07}, // R6 zeros ignored
    '{4'd7, 1'b0, 3'd0, 1'b0, 5'h00, 1'b1, 5'h02, 3'd3, 1'b0, 3'd3, 5'h05}, // R7 ack gp1
    '{4'd7, 1'b0, 3'd0, 1'b0, 5'h00, 1'b1, 5'h08, 3'd3, 1'b0, 3'd3, 5'h05}, // R7 ack idle bit
    '{4'd7, 1'b0, 3'd0, 1'b0, 5'h00, 1'b0, 5'h05, 3'd3, 1'b0, 3'd3, 5'h05}, // R7 data without strobe
    '{4'd8, 1'b0, 3'd0, 1'b1, 5'h10, 1'b0, 5'h00, 3'd3, 1'b0, 3'd3, 5'h15}, // R8 raise nmi
    '{4'd8, 1'b0, 3'd0, 1'b0, 5'h00, 1'b1, 5'h11, 3'd3, 1'b0, 3'd3, 5'h04}, // R8 ack nmi and gp0
    '{4'd7, 1'b0, 3'd0, 1'b1, 5'h04, 1'b1, 5'h04, 3'd3, 1'b0, 3'd3, 5'h00}, // R7 ack beats re-request
    '{4'd7, 1'b0, 3'd0, 1'b1, 5'h08, 1'b1, 5'h08, 3'd3, 1'b0, 3'd3, 5'h08}, // R7 idle ack, request lands
    '{4'd2, 1'b1, 3'd0, 1'b0, 5'h00, 1'b0, 5'h00, 3'd0, 1'b1, 3'd3, 5'h08}, // R2 accept flag 0
    '{4'd4, 1'b1, 3'd7, 1'b0, 5'h00, 1'b0, 5'h00, 3'd0, 1'b1, 3'd3, 5'h08}, // R4 refused
    '{4'd4, 1'b1, 3'd6, 1'b0, 5'h00, 1'b0, 5'h00, 3'd0, 1'b0, 3'd0, 5'h08}, // R4 refused on last busy cycle
    '{4'd2, 1'b1, 3'd6, 1'b0, 5'h00, 1'b0, 5'h00, 3'd6, 1'b1, 3'd0, 5'h08}, // R2 accept flag 6
    '{4'd7, 1'b0, 3'd0, 1'b0, 5'h00, 1'b1, 5'h08, 3'd6, 1'b1, 3'd0, 5'h00}, // R7 ack gp3
    '{4'd3, 1'b0, 3'd0, 1'b0, 5'h00, 1'b0, 5'h00, 3'd6, 1'b0, 3'd6, 5'h00}  // R3 peer sees 6
  };

  initial begin
    idleInputs();
    repeat (3) step();
    chkIdle("R1");
    rstN = 1'b1;
    step();
    chkIdle("R1");

    foreach (VEC[i]) begin
      string r;
      r = $sformatf("R%0d v%0d", VEC[i].rid, i);
      aFlagWe = VEC[i].fWe; aFlagIn = VEC[i].fIn;
      aReqWe = VEC[i].rWe; {aNmiReqIn, aGpReqIn} = VEC[i].rIn;
      bAckWe = VEC[i].kWe; {bNmiAckIn, bGpAckIn} = VEC[i].kIn;
      step();
      chk(r, "aFlagOwn", 8'(aFlagOwn), 8'(VEC[i].eOwn));
      chk(r, "aFlagBusy", 8'(aFlagBusy), 8'(VEC[i].eBusy));
      chk(r, "bPeerFlags", 8'(bPeerFlags), 8'(VEC[i].ePeer));
      chk(r, "aReq", 8'({aNmiReq, aGpReq}), 8'(VEC[i].eReq));
      chk(r, "bPend", 8'({bNmiPend, bGpPend}), 8'(VEC[i].eReq));
      chk(r, "aPend", 8'({aNmiPend, aGpPend}), 8'd0);
    end
    idleInputs();

    // R9: B-to-A flag transfer
    bFlagWe = 1; bFlagIn = 3'd2;
    step();
    bFlagWe = 0;
    chk("R9", "bFlagOwn", 8'(bFlagOwn), 8'd2);
    chk("R9", "bFlagBusy", 8'(bFlagBusy), 8'd1);
    chk("R9", "aPeerFlags", 8'(aPeerFlags), 8'd0);
    step();
    chk("R9", "aPeerFlags mid", 8'(aPeerFlags), 8'd0);
    step();
    chk("R9", "aPeerFlags", 8'(aPeerFlags), 8'd2);
    chk("R9", "bFlagBusy", 8'(bFlagBusy), 8'd0);

    // R9: B-to-A requests and acknowledges
    bReqWe = 1; bGpReqIn = 4'b1001; bNmiReqIn = 1;
    step();
    bReqWe = 0; bGpReqIn = 0; bNmiReqIn = 0;
    chk("R9", "aPend", 8'({aNmiPend, aGpPend}), 8'h19);
    chk("R9", "bReq", 8'({bNmiReq, bGpReq}), 8'h19);
    chk("R9", "bPend", 8'({bNmiPend, bGpPend}), 8'h00);
    aAckWe = 1; aGpAckIn = 4'b0001;
    step();
    chk("R9", "aPend", 8'({aNmiPend, aGpPend}), 8'h18);
    aGpAckIn = 4'b1000; aNmiAckIn = 1;
    step();
    aAckWe = 0; aGpAckIn = 0; aNmiAckIn = 0;
    chk("R9", "aPend", 8'({aNmiPend, aGpPend}), 8'h00);

    // R1: reset in mid-run
    aFlagWe = 1; aFlagIn = 3'd4; aReqWe = 1; aGpReqIn = 4'b0011;
    bReqWe = 1; bNmiReqIn = 1;
    step();
    idleInputs();
    chk("R1", "pre-reset aReq", 8'({aNmiReq, aGpReq}), 8'h03);
    rstN = 1'b0;
    step();
    step();
    chkIdle("R1");
    rstN = 1'b1;
    step();
    chkIdle("R1");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule